// File: doc/BRIEF.md
# Open-Page Address Mapper and Row Closer

This block sits in front of a DRAM command scheduler. It splits each incoming cache-line address into bank, row and column so that a short run of four neighbouring lines lands in one bank and the following run moves to the next bank. This trades some row locality for parallelism across banks. The split is purely combinational, so the decoded fields follow the request address in the same cycle.

For every bank the block remembers whether a row is open and which row it is. It flags a request that targets the open row as a row hit. An open row is not kept open without limit. It is closed after a fixed idle time, which is given in nanoseconds and turned into clock cycles from a clock-period parameter. It is also closed as soon as a prefetch-driven burst to that bank reports its end.

Closing a bank raises a per-bank precharge request. That request stays up until the scheduler acknowledges it. If several close events hit one bank, they merge into a single request.

Top module: `openpage_mapper`

## Requirements
- R1: With the defaults (32-bit address, 64-byte lines, 8 banks, runs of 4 lines, 5 upper column bits), address bits 5:0 are ignored. map_col[1:0] is addr[7:6], map_bank is addr[10:8], map_col[6:2] is addr[15:11] and map_row is addr[31:16]. As a result, lines 4k..4k+3 share one bank and line 4k+4 moves to the next bank, modulo 8.
- R2: map_bank, map_row and map_col follow req_addr combinationally, whether or not req_valid is high.
- R3: A request sampled at a clock edge opens its bank with its row, replacing any other open row. From then on, row_hit is high while req_valid is high and req_addr decodes to that bank and row, and it is low for any other row.
- R4: The idle limit is ceil(IDLE_NS*1000 / CLK_PERIOD_PS) cycles, which is 7 at 50 ns and 8 ns. If no request reaches an open bank, pre_req for that bank rises at exactly the limit-th edge after its last request, and the bank is then closed (row_hit low for its old row).
- R5: Every request to an open bank restarts its idle count, so the timeout is measured from the latest request.
- R6: A burst_done pulse naming an open bank closes that bank and raises its pre_req at the same edge.
- R7: A burst_done pulse naming a closed bank that has no request in that cycle has no effect: pre_req stays low.
- R8: pre_req for a bank stays high until pre_ack for that bank is sampled high. An acknowledge with no new close event clears it at that edge.
- R9: A timeout and a burst end on the same bank in the same cycle give one request, which one acknowledge clears with no second request following. A close event in the same cycle as an acknowledge leaves the request high.
- R10: Banks are independent: requests, bursts, timeouts and acknowledges for one bank do not change another bank's pre_req or row_hit.
- R11: While rst_n is low and after its release, every bank is closed and every pre_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Byte address of the requested line |
| burst_done | input | 1 | A prefetch-driven burst has ended |
| burst_bank | input | 3 | Bank of the ended burst |
| pre_ack | input | 8 | Per-bank acknowledge of the precharge request |
| map_bank | output | 3 | Decoded bank |
| map_row | output | 16 | Decoded row |
| map_col | output | 7 | Decoded column (line index within the row) |
| row_hit | output | 1 | The request targets its bank's open row |
| pre_req | output | 8 | Per-bank precharge request, held until acknowledged |

## Verification
The assertions assume three things about the inputs: pre_ack and burst_done are synchronous single-cycle or level signals, burst_bank is a valid bank index, and the bank count and run length are powers of two so that the decoded bank indexes the tracker array directly. The stimulus drives every input shortly after a rising edge and holds it for a whole cycle, so requests and bursts are sampled exactly once. Each scenario starts from a fresh reset, so an open bank left from an earlier scenario cannot time out in the middle of a later one. Combinational row-hit probes raise req_valid only between edges, so a probe never counts as a request.

// File: rtl/opm_pkg.sv
package opm_pkg;

  // Idle time in ns converted to a whole number of cycles, rounded up.
  function automatic int unsigned idle_cycles(input int unsigned idle_ns,
                                              input int unsigned period_ps);
    int unsigned span_ps;
    span_ps = idle_ns * 1000;
    return (span_ps + period_ps - 1) / period_ps;
  endfunction

  // Number of address bits left for the row once the other fields are taken.
  function automatic int unsigned row_bits(input int unsigned addr_w,
                                           input int unsigned off_w,
                                           input int unsigned run_w,
                                           input int unsigned bank_w,
                                           input int unsigned col_hi_w);
    return addr_w - off_w - run_w - bank_w - col_hi_w;
  endfunction

endpackage

// File: rtl/opm_addr_split.sv
module opm_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_BANKS  = 8,
  parameter int RUN_LINES  = 4,
  parameter int COL_HI_W   = 5,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int RUN_W  = $clog2(RUN_LINES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int COL_W  = RUN_W + COL_HI_W,
  localparam int ROW_W  = ADDR_W - OFF_W - RUN_W - BANK_W - COL_HI_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);

  localparam int BANK_LSB = OFF_W + RUN_W;
  localparam int COLH_LSB = BANK_LSB + BANK_W;
  localparam int ROW_LSB  = COLH_LSB + COL_HI_W;

  function automatic logic [BANK_W-1:0] pick_bank(input logic [ADDR_W-1:0] a);
    return a[BANK_LSB +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] pick_row(input logic [ADDR_W-1:0] a);
    return a[ROW_LSB +: ROW_W];
  endfunction

  // Column: upper part above the bank bits, lower part is the line within a run.
  function automatic logic [COL_W-1:0] pick_col(input logic [ADDR_W-1:0] a);
    return {a[COLH_LSB +: COL_HI_W], a[OFF_W +: RUN_W]};
  endfunction

  always_comb begin
    bank_o = pick_bank(addr_i);
    row_o  = pick_row(addr_i);
    col_o  = pick_col(addr_i);
  end

endmodule

// File: rtl/opm_bank_timer.sv
module opm_bank_timer #(
  parameter int ROW_W    = 16,
  parameter int IDLE_CYC = 7,
  localparam int CNT_W   = $clog2(IDLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [ROW_W-1:0] acc_row_i,
  input  logic             burst_i,
  input  logic             ack_i,
  output logic             is_open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             pre_req_o,
  output logic             timeout_evt_o,
  output logic             close_evt_o
);

  logic             is_open_q;
  logic [ROW_W-1:0] open_row_q;
  logic [CNT_W-1:0] idle_q;
  logic             pre_req_q;
  logic             burst_evt;

  // Internal events, named for the assertions below.
  assign timeout_evt_o = is_open_q & ~acc_i & (idle_q == CNT_W'(IDLE_CYC - 1));
  assign burst_evt     = burst_i & (is_open_q | acc_i);
  assign close_evt_o   = timeout_evt_o | burst_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open_q  <= 1'b0;
      open_row_q <= '0;
      idle_q     <= '0;
    end else if (close_evt_o) begin
      is_open_q <= 1'b0;
      idle_q    <= '0;
    end else if (acc_i) begin
      is_open_q  <= 1'b1;
      open_row_q <= acc_row_i;
      idle_q     <= '0;
    end else if (is_open_q) begin
      idle_q <= idle_q + CNT_W'(1);
    end
  end

  // Close events set the request; acknowledge clears it unless a new close lands.
  always_ff @(posedge clk) begin
    if (!rst_n)           pre_req_q <= 1'b0;
    else if (close_evt_o) pre_req_q <= 1'b1;
    else if (ack_i)       pre_req_q <= 1'b0;
  end

  assign is_open_o  = is_open_q;
  assign open_row_o = open_row_q;
  assign pre_req_o  = pre_req_q;

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    is_open_q |-> (idle_q < CNT_W'(IDLE_CYC)));

  a_r4_timeout_closes: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt_o |=> (!is_open_q && pre_req_q));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !burst_i) |=> (is_open_q && idle_q == '0));

  a_r6_burst_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_i && is_open_q) |=> (!is_open_q && pre_req_q));

  a_r7_burst_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_i && !is_open_q && !acc_i && !pre_req_q) |=> !pre_req_q);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req_q && !ack_i) |=> pre_req_q);

  a_r9_merge_over_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt_o && burst_i && ack_i) |=> (pre_req_q && !is_open_q));

endmodule

// File: rtl/openpage_mapper.sv
module openpage_mapper
  import opm_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int NUM_BANKS     = 8,
  parameter int RUN_LINES     = 4,
  parameter int COL_HI_W      = 5,
  parameter int IDLE_NS       = 50,
  parameter int CLK_PERIOD_PS = 8000,
  localparam int OFF_W    = $clog2(LINE_BYTES),
  localparam int RUN_W    = $clog2(RUN_LINES),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = RUN_W + COL_HI_W,
  localparam int ROW_W    = int'(row_bits(ADDR_W, OFF_W, RUN_W, BANK_W, COL_HI_W)),
  localparam int IDLE_CYC = int'(idle_cycles(IDLE_NS, CLK_PERIOD_PS))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 burst_done,
  input  logic [BANK_W-1:0]    burst_bank,
  input  logic [NUM_BANKS-1:0] pre_ack,
  output logic [BANK_W-1:0]    map_bank,
  output logic [ROW_W-1:0]     map_row,
  output logic [COL_W-1:0]     map_col,
  output logic                 row_hit,
  output logic [NUM_BANKS-1:0] pre_req
);

  logic [NUM_BANKS-1:0] bank_open;
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];
  logic [NUM_BANKS-1:0] timeout_evt;
  logic [NUM_BANKS-1:0] close_evt;
  logic [NUM_BANKS-1:0] acc_sel;
  logic [NUM_BANKS-1:0] burst_sel;

  opm_addr_split #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_BANKS (NUM_BANKS),
    .RUN_LINES (RUN_LINES),
    .COL_HI_W  (COL_HI_W)
  ) split_i (
    .addr_i(req_addr),
    .bank_o(map_bank),
    .row_o (map_row),
    .col_o (map_col)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign acc_sel[b]   = req_valid  & (map_bank   == BANK_W'(b));
    assign burst_sel[b] = burst_done & (burst_bank == BANK_W'(b));

    opm_bank_timer #(
      .ROW_W   (ROW_W),
      .IDLE_CYC(IDLE_CYC)
    ) timer_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_i        (acc_sel[b]),
      .acc_row_i    (map_row),
      .burst_i      (burst_sel[b]),
      .ack_i        (pre_ack[b]),
      .is_open_o    (bank_open[b]),
      .open_row_o   (bank_row[b]),
      .pre_req_o    (pre_req[b]),
      .timeout_evt_o(timeout_evt[b]),
      .close_evt_o  (close_evt[b])
    );
  end

  assign row_hit = req_valid & bank_open[map_bank] & (bank_row[map_bank] == map_row);

  // R3: a request repeated to the same row right after being sampled is a hit.
  a_r3_repeat_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && req_valid && $past(map_bank) == map_bank &&
     $past(map_row) == map_row &&
     !($past(burst_done) && $past(burst_bank) == map_bank)) |-> row_hit);

  // R11: no request is pending right after reset is released.
  a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pre_req == '0));

  // R10: a request only rises on a bank that saw its own close event.
  a_r10_bank_local: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(pre_req) & pre_req) & ~$past(close_evt)) == '0);

endmodule

// File: tb/openpage_mapper_tb.sv
module openpage_mapper_tb_top;

  localparam int LIMIT = (50 * 1000) / 8000 + (((50 * 1000) % 8000) != 0 ? 1 : 0);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        burst_done = 1'b0;
  logic [2:0]  burst_bank = '0;
  logic [7:0]  pre_ack = '0;
  logic [2:0]  map_bank;
  logic [15:0] map_row;
  logic [6:0]  map_col;
  logic        row_hit;
  logic [7:0]  pre_req;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  openpage_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .burst_done(burst_done), .burst_bank(burst_bank), .pre_ack(pre_ack),
    .map_bank(map_bank), .map_row(map_row), .map_col(map_col),
    .row_hit(row_hit), .pre_req(pre_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Builds an address from fields, using arithmetic on line numbers.
  function automatic logic [31:0] mk(input int row, input int bank, input int col);
    int line;
    line = row * 1024 + (col / 4) * 32 + bank * 4 + (col % 4);
    return 32'(line * 64);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; burst_done = 1'b0; pre_ack = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic access(input logic [31:0] a);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic burst(input int b);
    burst_done = 1'b1; burst_bank = 3'(b);
    @(posedge clk); #1;
    burst_done = 1'b0;
  endtask

  task automatic ack(input int b);
    pre_ack = 8'(1 << b);
    @(posedge clk); #1;
    pre_ack = '0;
  endtask

  // Combinational hit probe between edges; req_valid is never seen at an edge.
  task automatic probe(input logic [31:0] a, output logic hit);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1 hit = row_hit;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic h;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R11 pre_req during reset", 64'(pre_req), 64'h0);
    do_reset();
    check("R11 pre_req after reset", 64'(pre_req), 64'h0);
    probe(mk(0, 0, 0), h);
    check("R11 no hit after reset", 64'(h), 64'h0);
  endtask

  task automatic t_map();
    int base_line;
    do_reset();
    base_line = 12345;
    for (int i = 0; i < 16; i++) begin
      int line;
      line = base_line + i;
      req_addr = 32'(line * 64 + (i * 7) % 64);
      req_valid = 1'b0;
      #1;
      check("R1/R2 bank of consecutive line", 64'(map_bank), 64'((line / 4) % 8));
      check("R1 column", 64'(map_col), 64'(((line / 32) % 32) * 4 + line % 4));
      check("R1 row", 64'(map_row), 64'(line / 1024));
    end
    req_addr = 32'hDEAD_BEEF; #1;
    check("R1 row of mixed address", 64'(map_row), 64'h0000_DEAD);
    check("R1 bank of mixed address", 64'(map_bank), 64'((32'hDEAD_BEEF / 256) % 8));
    check("R1 col of mixed address", 64'(map_col),
          64'(((32'hDEAD_BEEF / 2048) % 32) * 4 + (32'hDEAD_BEEF / 64) % 4));
    req_addr = 32'h0000_00FF; #1;
    check("R1 fourth line stays bank 0", 64'(map_bank), 64'h0);
    req_addr = 32'h0000_0100; #1;
    check("R1 fifth line moves to bank 1", 64'(map_bank), 64'h1);
  endtask

  task automatic t_hit();
    logic h;
    do_reset();
    access(mk(5, 2, 3));
    probe(mk(5, 2, 9), h);
    check("R3 hit on open row", 64'(h), 64'h1);
    probe(mk(6, 2, 0), h);
    check("R3 miss on other row", 64'(h), 64'h0);
    probe(mk(5, 3, 0), h);
    check("R10 other bank not open", 64'(h), 64'h0);
    access(mk(6, 2, 1));
    probe(mk(6, 2, 7), h);
    check("R3 hit on new row", 64'(h), 64'h1);
    probe(mk(5, 2, 3), h);
    check("R3 old row replaced", 64'(h), 64'h0);
  endtask

  task automatic t_timeout();
    logic h;
    do_reset();
    access(mk(1, 4, 0));
    wait_edges(LIMIT - 1);
    check("R4 no precharge before limit", 64'(pre_req), 64'h0);
    wait_edges(1);
    check("R4 precharge at limit", 64'(pre_req), 64'h10);
    probe(mk(1, 4, 0), h);
    check("R4 bank closed after timeout", 64'(h), 64'h0);
  endtask

  task automatic t_restart();
    do_reset();
    access(mk(3, 0, 2));
    wait_edges(5);
    access(mk(3, 0, 6));
    wait_edges(LIMIT - 1);
    check("R5 count restarted", 64'(pre_req), 64'h0);
    wait_edges(1);
    check("R5 timeout from latest request", 64'(pre_req), 64'h01);
  endtask

  task automatic t_burst();
    logic h;
    do_reset();
    access(mk(2, 6, 0));
    wait_edges(1);
    burst(6);
    check("R6 burst end raises precharge", 64'(pre_req), 64'h40);
    probe(mk(2, 6, 0), h);
    check("R6 bank closed after burst", 64'(h), 64'h0);
  endtask

  task automatic t_burst_closed();
    logic h;
    do_reset();
    burst(3);
    wait_edges(2);
    check("R7 burst on closed bank ignored", 64'(pre_req), 64'h0);
    probe(mk(9, 3, 0), h);
    check("R7 bank stays closed", 64'(h), 64'h0);
  endtask

  task automatic t_sticky();
    do_reset();
    access(mk(4, 1, 0));
    wait_edges(LIMIT);
    check("R8 request raised", 64'(pre_req), 64'h02);
    wait_edges(20);
    check("R8 request held without ack", 64'(pre_req), 64'h02);
    ack(1);
    check("R8 ack clears", 64'(pre_req), 64'h0);
    wait_edges(10);
    check("R8 stays clear", 64'(pre_req), 64'h0);
  endtask

  task automatic t_coincide();
    do_reset();
    access(mk(7, 5, 0));
    wait_edges(LIMIT - 1);
    burst(5);
    check("R9 single request on coincidence", 64'(pre_req), 64'h20);
    ack(5);
    check("R9 one ack clears", 64'(pre_req), 64'h0);
    wait_edges(10);
    check("R9 no second request", 64'(pre_req), 64'h0);
    access(mk(7, 5, 0));
    pre_ack = 8'h20;
    wait_edges(LIMIT - 1);
    check("R9 ack with nothing pending", 64'(pre_req), 64'h0);
    wait_edges(1);
    check("R9 close wins over ack", 64'(pre_req), 64'h20);
    wait_edges(1);
    check("R9 held ack then clears", 64'(pre_req), 64'h0);
    pre_ack = '0;
  endtask

  task automatic t_indep();
    do_reset();
    access(mk(1, 0, 0));
    wait_edges(3);
    access(mk(1, 7, 0));
    wait_edges(3);
    check("R10 only bank 0 timed out", 64'(pre_req), 64'h01);
    ack(0);
    check("R10 ack bank 0 leaves bank 7", 64'(pre_req), 64'h00);
    wait_edges(3);
    check("R10 bank 7 times out on its own", 64'(pre_req), 64'h80);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_hit();
    t_timeout();
    t_restart();
    t_burst();
    t_burst_closed();
    t_sticky();
    t_coincide();
    t_indep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule